// File: doc/BRIEF.md
# Supply Reset Supervisor Timer

This block produces an active-low reset for logic powered from a regulated rail. It takes a flag that is already synchronised to the clock and says whether the rail is inside its regulation window, an enable, and a 3-bit release-delay code. An internal prescaler divides the system clock into a millisecond tick, and every timing decision is counted in those ticks.

A short dip out of regulation is filtered out: reset is asserted only when the rail stays out of regulation for a whole reaction window of ticks. When regulation comes back, reset is held for a delay chosen by the code (a power of two in ticks) and is then released. Code zero removes the delay, so the output acts as a plain power-good flag. The block is a Moore machine with five states. OFF is entered from reset or whenever enable is low. HOLD asserts reset while the rail is bad. WAIT counts the release delay. RUN means released. DIP means released while a dip is being timed.

The transitions are as follows. OFF→HOLD on enable. HOLD→WAIT when regulation returns with a nonzero code. HOLD→RUN when it returns with code zero. WAIT→HOLD on a new loss of regulation. WAIT→RUN when the delay expires. RUN→DIP on loss of regulation. DIP→RUN when regulation returns. DIP→HOLD when the reaction window expires. Any state goes to OFF when enable is low.

Top module: `supply_reset_timer`

## Requirements
- R1: While `rst_n` is low, and on every cycle after one in which `en` was sampled low, `rst_out_n` is 0.
- R2: After enable, `rst_out_n` stays 0 for as long as `in_reg` stays 0.
- R3: A loss of regulation that spans fewer than `REACT_TICKS` ticks leaves `rst_out_n` at 1.
- R4: A loss of regulation that spans `REACT_TICKS` ticks drives `rst_out_n` to 0. The fall happens only on the cycle after a tick.
- R5: For a delay code k in the range 1 to 7, `rst_out_n` rises after 2^k ticks of continuous regulation (2, 4, 8, 16, 32, 64 or 128 ticks). The rise happens only on the cycle after a tick.
- R6: With delay code 0, `rst_out_n` rises on the cycle after `in_reg` is sampled high in the held state.
- R7: If regulation is lost during the release delay, the delay count starts again from zero when regulation returns.
- R8: The delay code is captured only while the block is off or holding. A change made while a release is being timed has no effect on that release.
- R9: The reaction count clears whenever `in_reg` is 1. Two dips that are each shorter than the window, separated by at least one cycle in regulation, do not add up.
- R10: The tick fires once every `CLKS_PER_TICK` clock cycles, counted from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low forces reset out |
| in_reg | input | 1 | Synchronised flag: rail is in regulation |
| dly_code | input | CODE_W | Release delay code; delay is 2^code ticks, 0 means none |
| rst_out_n | output | 1 | Active-low supervised reset |

## Verification
The checker watches several relations on every cycle:
- reset follows a low enable;
- reset never releases while the rail is bad;
- a released output survives any cycle without a tick;
- assertion and timed release happen only on ticks;
- code zero releases at once;
- the captured code is frozen during the delay;
- ticks are evenly spaced.

The exact tick counts need the bench scenarios. These cover the dip length that separates ignored from acted on, the 2^k delay for every code, the delay restart after a renewed loss, the non-accumulation of back-to-back dips, and the immunity of a running release to code changes.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_HOLD = 3'd1,
        ST_WAIT = 3'd2,
        ST_RUN  = 3'd3,
        ST_DIP  = 3'd4
    } sup_state_e;

    function automatic logic released(sup_state_e s);
        return (s == ST_RUN) || (s == ST_DIP);
    endfunction

endpackage

// File: rtl/rsv_tick_gen.sv
module rsv_tick_gen #(
    parameter int unsigned DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_every
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) tick_o <= 1'b0;
                else        tick_o <= 1'b1;
            end
        end else begin : g_div
            localparam int unsigned PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pcnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            pcnt <= '0;
                else if (pcnt == LAST) pcnt <= '0;
                else                   pcnt <= pcnt + 1'b1;
            end
            assign tick_o = (pcnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/rsv_win_counter.sv
module rsv_win_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (step) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/supply_reset_timer.sv
module supply_reset_timer #(
    parameter int unsigned CLKS_PER_TICK = 100000,
    parameter int unsigned REACT_TICKS   = 25,
    parameter int unsigned CODE_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_reg,
    input  logic [CODE_W-1:0] dly_code,
    output logic              rst_out_n
);
    import rsv_pkg::*;

    localparam int unsigned DLY_W   = 2 ** CODE_W;
    localparam int unsigned REACT_W = $clog2(REACT_TICKS + 1);
    localparam logic [REACT_W-1:0] REACT_LAST = REACT_W'(REACT_TICKS - 1);

    sup_state_e        state, state_nx;
    logic              tick;
    logic [CODE_W-1:0] code_q;
    logic [DLY_W-1:0]  dly_cnt, dly_lim;
    logic [REACT_W-1:0] react_cnt;
    logic              dly_done, react_done;

    rsv_tick_gen #(.DIV(CLKS_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    // Delay code is latched only while reset is held.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            code_q <= '0;
        else if (state == ST_OFF || state == ST_HOLD)
            code_q <= dly_code;
    end

    assign dly_lim  = DLY_W'(1) << code_q;
    assign dly_done = tick && (dly_cnt == dly_lim - 1'b1);
    assign react_done = tick && (react_cnt == REACT_LAST);

    rsv_win_counter #(.W(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n),
        .clr(state != ST_WAIT || !in_reg),
        .step(tick),
        .cnt(dly_cnt)
    );

    rsv_win_counter #(.W(REACT_W)) u_react (
        .clk(clk), .rst_n(rst_n),
        .clr(state != ST_DIP || in_reg),
        .step(tick),
        .cnt(react_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  state_nx = ST_HOLD;
                ST_HOLD: if (in_reg) state_nx = (code_q == '0) ? ST_RUN : ST_WAIT;
                ST_WAIT: begin
                    if (!in_reg)       state_nx = ST_HOLD;
                    else if (dly_done) state_nx = ST_RUN;
                end
                ST_RUN:  if (!in_reg) state_nx = ST_DIP;
                ST_DIP: begin
                    if (in_reg)          state_nx = ST_RUN;
                    else if (react_done) state_nx = ST_HOLD;
                end
                default: state_nx = ST_OFF;
            endcase
        end
    end

    // Output logic
    always_comb begin
        rst_out_n = released(state);
    end
endmodule

// File: rtl/supply_reset_timer_chk.sv
module supply_reset_timer_chk #(
    parameter int unsigned CLKS_PER_TICK = 100000,
    parameter int unsigned CODE_W        = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               in_reg,
    input logic               rst_out_n,
    input logic               tick,
    input rsv_pkg::sup_state_e state,
    input logic [CODE_W-1:0]  code_q
);
    import rsv_pkg::*;

    localparam int unsigned GW = $clog2(CLKS_PER_TICK + 1) + 1;
    logic [GW-1:0] gap;
    logic          seen_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= '0;
            seen_tick <= 1'b0;
        end else if (tick) begin
            gap <= '0;
            seen_tick <= 1'b1;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    AST_EN_LOW_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !rst_out_n); // R1

    AST_NO_RELEASE_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_out_n && !in_reg) |=> !rst_out_n); // R2

    AST_DIP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out_n && en && !tick) |=> rst_out_n); // R3

    AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> ($past(tick) || !$past(en))); // R4

    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> ($past(tick) || $past(code_q) == '0)); // R5

    AST_CODE0_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && en && in_reg && code_q == '0) |=> rst_out_n); // R6

    AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |=> $stable(code_q)); // R8

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && seen_tick) |-> (gap == GW'(CLKS_PER_TICK - 1))); // R10
endmodule

bind supply_reset_timer supply_reset_timer_chk #(
    .CLKS_PER_TICK(CLKS_PER_TICK),
    .CODE_W(CODE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .in_reg(in_reg),
    .rst_out_n(rst_out_n), .tick(tick), .state(state), .code_q(code_q)
);

// File: tb/supply_reset_timer_test.sv
module supply_reset_timer_test;
    localparam int DIV   = 4;
    localparam int REACT = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       in_reg = 1'b0;
    logic [2:0] dly_code = 3'd0;
    wire        rst_out_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    supply_reset_timer #(.CLKS_PER_TICK(DIV), .REACT_TICKS(REACT), .CODE_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .in_reg(in_reg),
        .dly_code(dly_code), .rst_out_n(rst_out_n)
    );

    always #5 clk = ~clk;

    function automatic int exp_delay_ticks(input int code);
        return (code == 0) ? 0 : (1 << code);
    endfunction

    function automatic bit exp_dip_asserts(input int len);
        return len > (REACT - 1) * DIV;
    endfunction

    task automatic chk(input bit act, input bit exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rst_out_n=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic hold_state(input int code);
        en = 1'b0; in_reg = 1'b0;
        cyc(1);
        chk(rst_out_n, 1'b0, "R1");
        en = 1'b1; dly_code = 3'(code);
        cyc(3);
    endtask

    // raise regulation and check release window for the latched code
    task automatic release_check(input int code, input string req);
        int d;
        d = exp_delay_ticks(code);
        in_reg = 1'b1;
        if (d == 0) begin
            cyc(1);
            chk(rst_out_n, 1'b1, req);
        end else begin
            cyc((d - 1) * DIV);
            chk(rst_out_n, 1'b0, req);
            cyc(DIV + 2);
            chk(rst_out_n, 1'b1, req);
        end
    endtask

    initial begin
        for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        cyc(3);
        chk(rst_out_n, 1'b0, "R1");
        rst_n = 1'b1;
        cyc(2);
        chk(rst_out_n, 1'b0, "R1");

        // R2: enabled but never in regulation
        hold_state(0);
        cyc(300);
        chk(rst_out_n, 1'b0, "R2");

        // R6: code 0 power-good
        release_check(0, "R6");

        // R5: every nonzero code
        for (int c = 1; c < 8; c++) begin
            hold_state(c);
            release_check(c, "R5");
        end

        // R3 / R4 directed boundaries
        in_reg = 1'b0;
        cyc((REACT - 1) * DIV);
        chk(rst_out_n, 1'b1, "R3");
        in_reg = 1'b1;
        cyc(2);
        chk(rst_out_n, 1'b1, "R3");
        in_reg = 1'b0;
        cyc(REACT * DIV + 2);
        chk(rst_out_n, 1'b0, "R4");

        // R9: two short dips separated by one good cycle
        hold_state(0);
        release_check(0, "R6");
        in_reg = 1'b0; cyc((REACT - 1) * DIV);
        in_reg = 1'b1; cyc(1);
        in_reg = 1'b0; cyc((REACT - 1) * DIV);
        chk(rst_out_n, 1'b1, "R9");
        in_reg = 1'b1; cyc(2);
        chk(rst_out_n, 1'b1, "R9");

        // R7: loss during delay restarts the count
        hold_state(3);
        in_reg = 1'b1; cyc(5 * DIV);
        in_reg = 1'b0; cyc(2);
        chk(rst_out_n, 1'b0, "R7");
        release_check(3, "R7");

        // R8: code change during delay is ignored
        hold_state(2);
        in_reg = 1'b1; cyc(1);
        dly_code = 3'd7;
        cyc(3 * DIV - 1);
        chk(rst_out_n, 1'b0, "R8");
        cyc(DIV + 2);
        chk(rst_out_n, 1'b1, "R8");
        hold_state(5);
        in_reg = 1'b1; cyc(1);
        dly_code = 3'd1;
        cyc(4 * DIV);
        chk(rst_out_n, 1'b0, "R8");

        // R1: enable drop from released
        hold_state(0);
        release_check(0, "R6");
        en = 1'b0; cyc(1);
        chk(rst_out_n, 1'b0, "R1");

        // R10 via timing: random scenarios
        for (int t = 0; t < 24; t++) begin
            int code, len;
            bit exp;
            code = int'($urandom_range(0, 6));
            hold_state(code);
            release_check(code, "R5");
            if ($urandom_range(0, 1) == 1)
                len = int'($urandom_range(1, (REACT - 1) * DIV));
            else
                len = int'($urandom_range(REACT * DIV + 2, REACT * DIV + 30));
            exp = exp_dip_asserts(len);
            in_reg = 1'b0; cyc(len);
            chk(rst_out_n, !exp, exp ? "R4" : "R3");
            in_reg = 1'b1; cyc(1);
            if (!exp) chk(rst_out_n, 1'b1, "R10");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule